// File: doc/BRIEF.md
# Reloadable Serial Clock Divider

This block derives a serial bit clock from the bus clock. A 15-bit reload value
sets the period: one serial clock period lasts the effective reload value plus
one bus clock. Each period starts with the HIGH phase and then moves to the LOW
phase. When the period is an odd number of bus clocks, one phase has to be one
cycle longer than the other, and a clock-invert input picks which phase that is.
At the first bus clock of every period the block also gives a one-cycle bit-rate
tick, which the shift logic next to it uses to step its data.

The reload value comes in as one 16-bit write: a single strobe loads the whole
word into a staging register, and the top bit of the word is dropped. The divider
reads the staging value and the invert input only at a period boundary, so a
period already running always finishes with the widths it started with. When the
run enable is low, the serial clock stays HIGH and no tick is given. Raising the
enable starts a new period on the next bus clock edge.

Top module: `sclk_divider`

## Requirements
- R1: Under the synchronous active-low reset, `sclk` is 1 and `bit_tick` is 0. The staging reload value resets to 0.
- R2: The effective reload value E is the staging value, or 1 when the staging value is 0. The serial period is E+1 bus clocks. `bit_tick` is 1 for exactly the first bus clock of each period and 0 in every other cycle.
- R3: When E is odd, the HIGH and LOW phases each last (E+1)/2 bus clocks.
- R4: When E is even and `clk_inv` is 0, the HIGH phase lasts E/2+1 bus clocks and the LOW phase lasts E/2.
- R5: When E is even and `clk_inv` is 1, the HIGH phase lasts E/2 bus clocks and the LOW phase lasts E/2+1.
- R6: A staging value of 0 gives the minimum period of 2 bus clocks, with 1 cycle HIGH and 1 cycle LOW.
- R7: A cycle with `wr_en`=1 loads `wr_data[14:0]` into the staging register as one access. `wr_data[15]` has no effect. A write never changes the period that is running.
- R8: The staging value and `clk_inv` are sampled only at a period boundary. A change made during a period takes effect from the next period.
- R9: A bus clock edge that samples `run_en`=0 sets `sclk` to 1 and `bit_tick` to 0, and they stay there while `run_en` stays 0. The first edge that samples `run_en`=1 after that starts a new period.
- R10: Every period begins with the HIGH phase. A `bit_tick` pulse always coincides with `sclk`=1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous reset, active low |
| run_en | input | 1 | Divider run enable |
| clk_inv | input | 1 | Chooses the longer phase for odd periods (0: HIGH, 1: LOW) |
| wr_en | input | 1 | Strobe that loads the reload word |
| wr_data | input | 16 | Reload word; bits 14:0 are used |
| sclk | output | 1 | Serial clock |
| bit_tick | output | 1 | One-cycle pulse at the start of each serial period |

## Verification
The bench uses the default parameters: a 15-bit reload field inside a 16-bit write word. This covers the zero reload, the smallest odd and even reload values with both invert settings, and a write that has the dropped top bit set. It also covers the largest even reload value, 0x7FFE, which gives a 32767-cycle period. With that value the bench confirms that the phase counters reach their full width without wrapping. The bench also checks the boundary behaviour: it changes the reload value and the invert setting partway through a period, and it writes a new value while the divider is idle.

// File: rtl/sclkdiv_pkg.sv
// Shared types for the serial clock divider.
// Assumes: the serial clock level is the same as the phase encoding.
package sclkdiv_pkg;
    typedef enum logic {
        PH_LOW  = 1'b0,
        PH_HIGH = 1'b1
    } phase_e;
endpackage

// File: rtl/sclkdiv_reload_reg.sv
// Staging register for the reload value. A single strobe loads the whole word.
// Assumes: WORD_W >= RELOAD_W; bits above RELOAD_W are dropped.
module sclkdiv_reload_reg #(
    parameter int RELOAD_W = 15,
    parameter int WORD_W   = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [WORD_W-1:0]   wr_data,
    output logic [RELOAD_W-1:0] reload
);
    localparam int DROP_W = WORD_W - RELOAD_W;

    // Purpose: load the low field of the written word in one access.
    always_ff @(posedge clk) begin
        if (!rst_n)
            reload <= '0;
        else if (wr_en)
            reload <= wr_data[RELOAD_W-1:0];
    end

    generate
        if (DROP_W > 0) begin : g_drop
            logic unused_hi;
            // Purpose: mark the dropped upper bits as intentionally unused.
            assign unused_hi = ^wr_data[WORD_W-1:RELOAD_W];
        end
    endgenerate

    assert_capture_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (reload == $past(wr_data[RELOAD_W-1:0])));

    assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(reload));
endmodule

// File: rtl/sclkdiv_phase_calc.sv
// Works out the HIGH and LOW phase lengths for a reload value.
// Assumes: the caller samples the results only at a period boundary.
module sclkdiv_phase_calc #(
    parameter int RELOAD_W = 15
) (
    input  logic [RELOAD_W-1:0] reload,
    input  logic                inv,
    output logic [RELOAD_W-1:0] high_len,
    output logic [RELOAD_W-1:0] low_len
);
    logic [RELOAD_W-1:0] eff;
    logic [RELOAD_W-1:0] half;
    logic                eff_odd;

    // Purpose: use 1 in place of a zero reload, then split the period.
    always_comb begin
        eff     = (reload == '0) ? RELOAD_W'(1) : reload;
        half    = eff >> 1;
        eff_odd = eff[0];
        if (eff_odd) begin
            high_len = half + RELOAD_W'(1);
            low_len  = half + RELOAD_W'(1);
        end else if (inv) begin
            high_len = half;
            low_len  = half + RELOAD_W'(1);
        end else begin
            high_len = half + RELOAD_W'(1);
            low_len  = half;
        end
    end
endmodule

// File: rtl/sclkdiv_phase_ctr.sv
// Phase down-counter: runs the HIGH phase, then the LOW phase, and gives
// a tick at the start of every period.
// Assumes: high_len and low_len are at least 1 and are valid at every edge.
module sclkdiv_phase_ctr
    import sclkdiv_pkg::*;
#(
    parameter int RELOAD_W = 15
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                run_en,
    input  logic [RELOAD_W-1:0] high_len,
    input  logic [RELOAD_W-1:0] low_len,
    output logic                load,
    output logic                sclk,
    output logic                tick
);
    phase_e              phase;
    logic                running;
    logic [RELOAD_W-1:0] cnt;
    logic [RELOAD_W-1:0] low_len_q;
    logic                period_end;

    // Purpose: find the last cycle of a period and the moment to start one.
    always_comb begin
        period_end = running && (phase == PH_LOW) && (cnt == '0);
        load       = run_en && (!running || period_end);
    end

    // Purpose: step the phase counter and drive the registered outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            running   <= 1'b0;
            phase     <= PH_HIGH;
            cnt       <= '0;
            low_len_q <= '0;
            tick      <= 1'b0;
        end else if (!run_en) begin
            running   <= 1'b0;
            phase     <= PH_HIGH;
            cnt       <= '0;
            tick      <= 1'b0;
        end else if (load) begin
            running   <= 1'b1;
            phase     <= PH_HIGH;
            cnt       <= high_len - RELOAD_W'(1);
            low_len_q <= low_len;
            tick      <= 1'b1;
        end else begin
            tick <= 1'b0;
            if (cnt != '0) begin
                cnt <= cnt - RELOAD_W'(1);
            end else begin
                phase <= PH_LOW;
                cnt   <= low_len_q - RELOAD_W'(1);
            end
        end
    end

    // Purpose: the serial clock level is the phase.
    assign sclk = (phase == PH_HIGH);

    assert_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !run_en |=> (sclk && !tick));

    assert_single_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);

    assert_rise_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(sclk) && $past(run_en)) |-> tick);

    assert_tick_high_R10: assert property (@(posedge clk) disable iff (!rst_n)
        tick |-> sclk);

    assert_low_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(low_len_q));
endmodule

// File: rtl/sclk_divider.sv
// Top of the reloadable serial clock divider. Connects the staging register,
// the phase length calculation and the phase counter.
// Assumes: the invert input is a quasi-static setting and is sampled at boundaries.
module sclk_divider #(
    parameter int RELOAD_W = 15,
    parameter int WORD_W   = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_en,
    input  logic              clk_inv,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_data,
    output logic              sclk,
    output logic              bit_tick
);
    logic [RELOAD_W-1:0] staged;
    logic [RELOAD_W-1:0] high_len;
    logic [RELOAD_W-1:0] low_len;
    logic                load;

    sclkdiv_reload_reg #(.RELOAD_W(RELOAD_W), .WORD_W(WORD_W)) reg_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .reload  (staged)
    );

    sclkdiv_phase_calc #(.RELOAD_W(RELOAD_W)) calc_i (
        .reload   (staged),
        .inv      (clk_inv),
        .high_len (high_len),
        .low_len  (low_len)
    );

    sclkdiv_phase_ctr #(.RELOAD_W(RELOAD_W)) ctr_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .run_en   (run_en),
        .high_len (high_len),
        .low_len  (low_len),
        .load     (load),
        .sclk     (sclk),
        .tick     (bit_tick)
    );

    assert_load_starts_R2: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (bit_tick && sclk));
endmodule

// File: tb/sclk_divider_tb_top.sv
module sclk_divider_tb_top;
    localparam int LIM = 40000;
    localparam int NV  = 10;
    localparam int V_DATA [NV] = '{32'h0000, 32'h0001, 32'h0002, 32'h0002, 32'h0003,
                                   32'h0006, 32'h0006, 32'h0009, 32'h8004, 32'h000A};
    localparam int V_INV  [NV] = '{0, 0, 0, 1, 1, 0, 1, 0, 0, 1};
    localparam int V_HIGH [NV] = '{1, 1, 2, 1, 2, 4, 3, 5, 3, 5};
    localparam int V_LOW  [NV] = '{1, 1, 1, 2, 2, 3, 4, 5, 2, 6};
    localparam string V_REQ [NV] = '{"R6", "R3", "R4", "R5", "R3",
                                     "R4", "R5", "R3", "R7", "R5"};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        run_en = 1'b1;
    logic        clk_inv = 1'b0;
    logic        wr_en = 1'b0;
    logic [15:0] wr_data = '0;
    logic        sclk;
    logic        bit_tick;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    sclk_divider dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .run_en   (run_en),
        .clk_inv  (clk_inv),
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .sclk     (sclk),
        .bit_tick (bit_tick)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_tick(output bit found);
        found = 1'b0;
        for (int i = 0; i < LIM && !found; i++) begin
            @(negedge clk);
            if (bit_tick) found = 1'b1;
        end
    endtask

    // Starts on a sample that shows a tick; ends on the next tick sample.
    task automatic measure(output int h, output int l, output bit tick_ok);
        tick_ok = 1'b1;
        h = 1;
        l = 0;
        do begin
            @(negedge clk);
            if (sclk) h++;
            if (bit_tick) tick_ok = 1'b0;
        end while (sclk && h < LIM);
        l = 1;
        do begin
            @(negedge clk);
            if (!sclk) l++;
        end while (!sclk && l < LIM);
        if (!bit_tick) tick_ok = 1'b0;
    endtask

    task automatic run_period(input string req, input int eh, input int el);
        int h, l;
        bit ok, found;
        wait_tick(found);
        check(found, "R2", int'(found), 1);
        measure(h, l, ok);
        check(h == eh, req, h, eh);
        check(l == el, req, l, el);
        check(ok, "R2", int'(ok), 1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        int h, l;
        bit ok, found;

        // R1: held in reset with run enabled
        repeat (2) @(negedge clk);
        check(sclk && !bit_tick, "R1", {sclk, bit_tick}, 2);
        rst_n  = 1'b1;
        run_en = 1'b0;
        @(negedge clk);
        check(sclk && !bit_tick, "R1", {sclk, bit_tick}, 2);
        // R1/R6: the staging value reset to 0 gives a 1+1 period
        run_en = 1'b1;
        run_period("R1", 1, 1);
        run_en = 1'b0;
        @(negedge clk);

        // Vector table: write, enable, measure one full period
        for (int v = 0; v < NV; v++) begin
            wr_en   = 1'b1;
            wr_data = 16'(V_DATA[v]);
            clk_inv = V_INV[v][0];
            @(negedge clk);
            wr_en  = 1'b0;
            run_en = 1'b1;
            run_period(V_REQ[v], V_HIGH[v], V_LOW[v]);
            run_en = 1'b0;
            @(negedge clk);
        end

        // R8: change the value and the invert setting partway through a period
        wr_en = 1'b1; wr_data = 16'd3; clk_inv = 1'b0;
        @(negedge clk);
        wr_en = 1'b0; run_en = 1'b1;
        wait_tick(found);
        wr_en = 1'b1; wr_data = 16'd6; clk_inv = 1'b1;
        measure(h, l, ok);
        wr_en = 1'b0;
        check(h == 2 && l == 2, "R8", h * 100 + l, 202);
        measure(h, l, ok);
        check(h == 3 && l == 4 && ok, "R8", h * 100 + l, 304);

        // R9/R7: stop the run, write while idle, outputs stay idle
        run_en = 1'b0;
        ok = 1'b1;
        for (int i = 0; i < 6; i++) begin
            wr_en = (i == 2); wr_data = 16'd9;
            @(negedge clk);
            if (!(sclk && !bit_tick)) ok = 1'b0;
        end
        wr_en = 1'b0;
        check(ok, "R9", int'(ok), 1);
        // R10: restart begins with a HIGH phase and a tick on the next edge
        run_en = 1'b1;
        @(negedge clk);
        check(sclk && bit_tick, "R10", {sclk, bit_tick}, 3);
        measure(h, l, ok);
        check(h == 5 && l == 5 && ok, "R3", h * 100 + l, 505);
        run_en = 1'b0;
        @(negedge clk);

        // R4/R2: largest even value, full-width counters
        wr_en = 1'b1; wr_data = 16'h7FFE; clk_inv = 1'b0;
        @(negedge clk);
        wr_en = 1'b0; run_en = 1'b1;
        wait_tick(found);
        measure(h, l, ok);
        check(h == 16384 && l == 16383, "R4", h * 100000 + l, 16384 * 100000 + 16383);
        check(h + l == 32767 && ok, "R2", h + l, 32767);
        run_en = 1'b0;
        @(negedge clk);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule